// File: doc/BRIEF.md
# Interleaved Banked Word Memory

This block is a word-addressed storage array built from several identical banks. A run-time mode input decides where the bank number sits in the address. In high-order mode the top address bits pick the bank, so neighbouring addresses stay in one bank and each access enables only that bank. In low-order mode the bottom address bits pick the bank, so neighbouring addresses fall in different banks.

Low-order mode also allows a wide access. The address must be aligned to the bank count. The access enables every bank in the same cycle and moves one word per bank in a single beat. Narrow accesses move one word on lane 0 of the data buses. Read data is registered. It appears one cycle after the request, together with a valid strobe. A request that cannot be served raises an error pulse instead and changes nothing.

Switching the mode never moves stored words. Only the decoding of an address into a bank and a row changes, so after a switch the same address can name a different physical word.

Top module: `banked_mem`

## Requirements
- R1: While reset is held and on the first cycle after it, `rvalid` and `err` are 0 and `rdata` is all zeros.
- R2: With `low_mode`=0 the bank number is the top log2(NBANKS) bits of `addr` and the row is the remaining low bits, so consecutive addresses share a bank.
- R3: With `low_mode`=1 the bank number is the bottom log2(NBANKS) bits of `addr` and the row is the remaining high bits, so consecutive addresses fall in different banks.
- R4: A narrow read (`wide`=0) returns the addressed word on lane 0 of `rdata` (bits WORD_W-1:0) one cycle after the request with `rvalid`=1; all other lanes are 0.
- R5: A wide access (`wide`=1) in low-order mode at an address whose bottom log2(NBANKS) bits are 0 enables every bank in that cycle; lane i (bits i*WORD_W +: WORD_W) of `wdata`/`rdata` carries the word at `addr`+i.
- R6: A wide request that is misaligned, or that is made in high-order mode, gives `err`=1 for one cycle after the request and `rvalid`=0, and writes nothing.
- R7: In high-order mode a narrow request enables exactly one bank.
- R8: Changing `low_mode` moves no data: the word in bank b, row r is address b*ROWS+r in high-order mode and address r*NBANKS+b in low-order mode.
- R9: A write request never raises `rvalid`, and `rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| low_mode | input | 1 | 1 = low-order bank select, 0 = high-order |
| wide | input | 1 | 1 = one word per bank in one beat |
| addr | input | log2(NBANKS*ROWS) | Word address |
| wdata | input | NBANKS*WORD_W | Write data, lane i = word i |
| rdata | output | NBANKS*WORD_W | Registered read data, lane i = word i |
| rvalid | output | 1 | Read data valid, one cycle after a read |
| err | output | 1 | Request refused, one cycle after it |

## Verification
The bench writes words in one mode and reads them back in the other. A design that kept the bank bits in one place regardless of mode, or that remapped data on a switch, returns the wrong physical word. Wide beats are checked lane by lane against narrow reads of the same words, which exposes reversed or shifted lanes. Misaligned wide requests and wide requests in high-order mode are sent with write enabled, then the target words are read back; a design that let them through corrupts neighbouring banks or shows a spurious valid strobe. Writes are checked for a quiet `rvalid` and for `rdata` that does not change.

// File: rtl/banked_mem.sv
module banked_mem #(
  parameter int NBANKS = 4,
  parameter int WORD_W = 16,
  parameter int ROWS   = 16,
  localparam int BB    = $clog2(NBANKS),
  localparam int RB    = $clog2(ROWS),
  localparam int AW    = BB + RB
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic                     low_mode,
  input  logic                     wide,
  input  logic [AW-1:0]            addr,
  input  logic [NBANKS*WORD_W-1:0] wdata,
  output logic [NBANKS*WORD_W-1:0] rdata,
  output logic                     rvalid,
  output logic                     err
);

  logic [BB-1:0] sel_bank;
  logic [RB-1:0] sel_row;
  logic          bad, go;
  logic [NBANKS-1:0] bank_en;
  logic [WORD_W-1:0] rd_word [NBANKS];
  logic [NBANKS*WORD_W-1:0] next_rdata;

  assign sel_bank = low_mode ? addr[BB-1:0]  : addr[AW-1 -: BB];
  assign sel_row  = low_mode ? addr[AW-1:BB] : addr[RB-1:0];
  assign bad      = req && wide && (!low_mode || addr[BB-1:0] != '0);
  assign go       = req && !bad;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [WORD_W-1:0] mem [ROWS];
    logic [WORD_W-1:0] wword;

    assign bank_en[b] = go && (wide || sel_bank == BB'(b));
    assign wword      = wide ? wdata[b*WORD_W +: WORD_W] : wdata[WORD_W-1:0];
    assign rd_word[b] = mem[sel_row];

    always_ff @(posedge clk)
      if (bank_en[b] && we) mem[sel_row] <= wword;
  end

  always_comb begin
    next_rdata = '0;
    if (wide) begin
      for (int b = 0; b < NBANKS; b++) next_rdata[b*WORD_W +: WORD_W] = rd_word[b];
    end else begin
      next_rdata[WORD_W-1:0] = rd_word[sel_bank];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      err    <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= go && !we;
      err    <= bad;
      if (go && !we) rdata <= next_rdata;
    end
  end

  a_r4_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(req && !we));
  a_r6_err_after_wide: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(req && wide) && !rvalid));
  a_r7_one_bank_high: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !low_mode && !wide) |-> $countones(bank_en) == 1);
  a_r5_all_banks_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (req && low_mode && wide && addr[BB-1:0] == '0) |-> &bank_en);
  a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |=> (!rvalid && $stable(rdata)));

endmodule

// File: tb/banked_mem_bench.sv
`timescale 1ns/1ps
module banked_mem_bench;
  localparam int NB = 4, W = 16, ROWS = 16;
  localparam int BB = $clog2(NB), RB = $clog2(ROWS), AW = BB + RB;

  logic clk = 0, rst_n = 0, req = 0, we = 0, low_mode = 0, wide = 0;
  logic [AW-1:0] addr = '0;
  logic [NB*W-1:0] wdata = '0, rdata;
  logic rvalid, err;

  banked_mem #(.NBANKS(NB), .WORD_W(W), .ROWS(ROWS)) u_banked_mem (
    .clk, .rst_n, .req, .we, .low_mode, .wide, .addr, .wdata, .rdata, .rvalid, .err);

  always #2.5 clk = ~clk;

  typedef struct { logic chk; logic [NB*W-1:0] d; logic v; logic e; string tag; } item_t;
  item_t q[$];
  int tests = 0, fails = 0;
  logic [W-1:0] phys [NB][ROWS];
  logic [NB*W-1:0] last_rd = '0;

  function automatic void locate(input logic lm, input int a, output int b, output int r);
    if (lm) begin b = a % NB; r = a / NB; end
    else    begin b = a / ROWS; r = a % ROWS; end
  endfunction

  task automatic push(input logic chk, input logic [NB*W-1:0] d, input logic v, input logic e, input string tag);
    item_t it;
    it.chk = chk; it.d = d; it.v = v; it.e = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic access(input logic w, input logic lm, input logic wd, input int a,
                        input logic [NB*W-1:0] d, input string tag);
    int b, r;
    logic bad;
    logic [NB*W-1:0] exp;
    @(negedge clk);
    req = 1; we = w; low_mode = lm; wide = wd; addr = AW'(a); wdata = d;
    @(posedge clk); #1;
    req = 0;
    bad = wd && (!lm || (a % NB) != 0);
    exp = '0;
    if (!bad) begin
      for (int i = 0; i < (wd ? NB : 1); i++) begin
        locate(lm, a + i, b, r);
        if (w) phys[b][r] = d[i*W +: W];
        exp[i*W +: W] = phys[b][r];
      end
    end
    if (bad)    push(0, '0, 0, 1, tag);
    else if (w) push(1, last_rd, 0, 0, tag);
    else begin  push(1, exp, 1, 0, tag); last_rd = exp; end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      tests++;
      if (rvalid !== it.v || err !== it.e || (it.chk && rdata !== it.d)) begin
        fails++;
        $display("FAIL %s: rvalid=%b err=%b rdata=%h expected rvalid=%b err=%b rdata=%h",
                 it.tag, rvalid, err, rdata, it.v, it.e, it.d);
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++; tests++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (rvalid !== 0 || err !== 0 || rdata !== '0) begin
      fails++; $display("FAIL R1: rvalid=%b err=%b rdata=%h expected 0 0 0", rvalid, err, rdata);
    end
    rst_n = 1;
    @(negedge clk);
    tests++;
    if (rvalid !== 0 || err !== 0 || rdata !== '0) begin
      fails++; $display("FAIL R1 after release: rvalid=%b err=%b rdata=%h expected 0 0 0", rvalid, err, rdata);
    end
    // fill everything in high-order mode, one word at a time
    for (int a = 0; a < NB * ROWS; a++) access(1, 0, 0, a, (NB*W)'(16'hA000 + a), "R9 write");
    // high-order narrow reads: consecutive addresses in one bank
    for (int a = 0; a < 6; a++) access(0, 0, 0, a, '0, "R2/R4 high read");
    access(0, 0, 0, 63, '0, "R2 high top bank");
    // switch to low-order and read: data must not move
    for (int a = 0; a < 8; a++) access(0, 1, 0, a, '0, "R8/R3 low read after switch");
    // low-order narrow writes then high-order reads of the same cells
    access(1, 1, 0, 5, (NB*W)'(16'h5555), "R3 low write");
    access(0, 0, 0, 17, '0, "R8 high view of low write");
    access(0, 1, 0, 5, '0, "R3 low read back");
    // wide aligned beat
    access(1, 1, 1, 8, {16'hD003, 16'hD002, 16'hD001, 16'hD000}, "R5 wide write");
    access(0, 1, 1, 8, '0, "R5 wide read");
    for (int i = 0; i < NB; i++) access(0, 1, 0, 8 + i, '0, "R5 lane narrow check");
    access(0, 0, 0, 2, '0, "R8 high view of wide row");
    access(0, 1, 1, 0, '0, "R5 wide read row 0");
    // refused requests
    access(1, 1, 1, 9, {4{16'hBAD0}}, "R6 misaligned wide write");
    access(0, 1, 1, 8, '0, "R6 neighbours untouched");
    access(0, 1, 1, 10, '0, "R6 misaligned wide read");
    access(1, 0, 1, 0, {4{16'hBAD1}}, "R6 wide in high mode");
    access(0, 0, 0, 0, '0, "R6 high word untouched");
    access(0, 0, 0, 1, '0, "R7 high single bank");
    access(1, 0, 0, 33, (NB*W)'(16'h7777), "R7 high write one bank");
    access(0, 1, 1, 4, '0, "R7 other banks same row unchanged");
    access(1, 1, 0, 6, (NB*W)'(16'h1234), "R9 write keeps rdata");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule